// File: doc/BRIEF.md
# Embedded Controller Host Command/Data Port

This block is the host-side byte interface of an embedded controller. The host writes single bytes to either a command port or a data port and reads bytes back from the data port. A status byte reports how each byte is progressing. Every byte the host writes raises a busy flag. The block takes the byte after a fixed number of processing cycles and then clears the flag. Read results are placed in a data register, and a data-ready flag tells the host to collect them.

Five commands are decoded:

- Read: the next data byte is an address, and the byte stored there is returned on the data port.
- Write: the next data byte is an address, and the data byte after it is stored there.
- Burst on and burst off: set and clear a burst flag. While the flag is set, the controller's own writes to multi-byte values are dropped, so the host sees those values in a consistent state.
- Query: takes the lowest-numbered pending event off the pending set and returns its position, counted from 1.

Events are raised by pulses on an input vector. A summary flag in the status byte shows whether any event is pending.

The address space is a 256-byte register file inside the block. The controller itself writes into it through a separate internal write port.

Top module: `ec_hostport`

## Requirements
- R1: After reset the status byte is 0x00, the data port reads 0x00, and every register-file byte is 0x00.
- R2: Status bit 1 (busy) is 1 from the clock edge that samples a host write until exactly PROC_CYC edges later, when the byte is taken. With the default PROC_CYC of 2, it reads 1 after the write edge and after the next edge, and 0 after the edge after that.
- R3: Status bit 3 is set by a host write to the command port and cleared by a host write to the data port, at the edge that samples the write.
- R4: Command 0x80 followed by an address byte loads the addressed byte into the data port and sets status bit 0 (data ready). A host read of the data port clears bit 0.
- R5: Command 0x81 followed by an address byte and then a value byte stores the value at that address.
- R6: Status bit 2 (processing) is 1 from the moment a read or write command is taken until the final data byte of that command is taken.
- R7: Command 0x84 returns the 1-based position of the lowest pending event (bit 0 gives 1, bit 31 gives 32) and clears only that event. It returns 0 when no event is pending. In both cases it sets status bit 0.
- R8: Status bit 5 is 1 exactly while at least one event is pending. A pulse on an event input makes that event pending at the next edge.
- R9: Command 0x82 sets status bit 4 (burst) and command 0x83 clears it. The bit changes only when a command byte is taken.
- R10: While burst is on, an internal write flagged multi-byte is dropped. Internal writes not flagged multi-byte, and all internal writes made while burst is off, are stored.
- R11: A command byte taken while another command is still in progress aborts the earlier command. An unknown command code is ignored. A data byte taken with no command in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | One-cycle host byte write strobe |
| host_cmd_sel | input | 1 | 1 selects the command port, 0 selects the data port |
| host_wdata | input | 8 | Byte written by the host |
| host_rd | input | 1 | One-cycle host data-port read strobe |
| host_rdata | output | 8 | Data port value |
| host_status | output | 8 | Status byte: bit 0 ready, 1 busy, 2 processing, 3 last write was a command, 4 burst, 5 event pending |
| evt_set | input | NEVT | Pulses that mark events pending |
| int_we | input | 1 | Internal register-file write strobe |
| int_addr | input | ADDR_W | Internal write address |
| int_wdata | input | 8 | Internal write data |
| int_multi | input | 1 | Marks the internal write as part of a multi-byte value |

## Verification
A host byte is taken PROC_CYC edges after the edge that samples its strobe. Its effects appear together at that edge: the busy flag clears, the data port and ready flag are loaded, the processing and burst flags change, and any register-file write or event clear is applied. The last-command flag and the busy set follow at the strobe edge itself, and event pulses and internal writes act one edge after they are driven. The bench drives all inputs at falling edges. It checks busy-flag timing edge by edge, and otherwise polls the busy flag at falling edges before it samples any result, so every check falls after the edge that produced the value under test.

// File: rtl/ec_hp_pkg.sv
package ec_hp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RADDR = 2'd1,
      ST_WADDR = 2'd2,
      ST_WDATA = 2'd3
   } seq_st_e;

   localparam logic [7:0] CMD_RD   = 8'h80;
   localparam logic [7:0] CMD_WR   = 8'h81;
   localparam logic [7:0] CMD_BON  = 8'h82;
   localparam logic [7:0] CMD_BOFF = 8'h83;
   localparam logic [7:0] CMD_QRY  = 8'h84;

   localparam int SB_RDY   = 0;
   localparam int SB_BUSY  = 1;
   localparam int SB_PROC  = 2;
   localparam int SB_LCMD  = 3;
   localparam int SB_BURST = 4;
   localparam int SB_EVT   = 5;
endpackage

// File: rtl/ec_hp_regfile.sv
module ec_hp_regfile #(
   parameter int ADDR_W         = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              h_we,
   input  logic [ADDR_W-1:0] h_waddr,
   input  logic [7:0]        h_wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata,
   input  logic              i_we,
   input  logic [ADDR_W-1:0] i_addr,
   input  logic [7:0]        i_wdata,
   input  logic              i_multi,
   input  logic              lock
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];
   logic       i_ok;

   // internal write dropped for multi-byte data while locked
   assign i_ok  = i_we && !(lock && i_multi);
   assign rdata = mem[raddr];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else begin
               if (i_ok) mem[i_addr] <= i_wdata;
               if (h_we) mem[h_waddr] <= h_wdata;   // host wins a collision
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (i_ok && rst_n) mem[i_addr] <= i_wdata;
            if (h_we && rst_n) mem[h_waddr] <= h_wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/ec_hp_evtq.sv
module ec_hp_evtq #(
   parameter int NEVT = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NEVT-1:0] set_vec,
   input  logic            pop,
   output logic            any,
   output logic [7:0]      idx
);
   logic [NEVT-1:0] pend;
   logic [NEVT-1:0] lowest;

   assign lowest = pend & (~pend + NEVT'(1));
   assign any    = |pend;

   always_comb begin
      idx = 8'd0;
      for (int i = NEVT - 1; i >= 0; i--) begin
         if (pend[i]) idx = 8'(i + 1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~(pop ? lowest : '0)) | set_vec;
   end
endmodule

// File: rtl/ec_hp_seq.sv
module ec_hp_seq
   import ec_hp_pkg::*;
#(
   parameter int PROC_CYC = 2,
   parameter int ADDR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_cmd_sel,
   input  logic [7:0]        host_wdata,
   input  logic              host_rd,
   input  logic [7:0]        evt_idx,
   input  logic              evt_any,
   input  logic [7:0]        mem_rdata,
   output logic [ADDR_W-1:0] mem_raddr,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [7:0]        mem_wdata,
   output logic              evt_pop,
   output logic              burst_on,
   output logic [7:0]        host_rdata,
   output logic [7:0]        host_status
);
   localparam int CNT_W = $clog2(PROC_CYC + 1);

   seq_st_e           st;
   logic              busy, rdy, lcmd, burst, is_cmd;
   logic [7:0]        byte_q, rdata_q;
   logic [ADDR_W-1:0] waddr_q;
   logic [CNT_W-1:0]  cnt;
   logic              take;

   // a new host write in the take cycle replaces the pending byte
   assign take = busy && (cnt == CNT_W'(1)) && !host_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         busy    <= 1'b0;
         rdy     <= 1'b0;
         lcmd    <= 1'b0;
         burst   <= 1'b0;
         is_cmd  <= 1'b0;
         byte_q  <= '0;
         rdata_q <= '0;
         waddr_q <= '0;
         cnt     <= '0;
      end else begin
         if (host_wr) begin
            busy   <= 1'b1;
            byte_q <= host_wdata;
            is_cmd <= host_cmd_sel;
            lcmd   <= host_cmd_sel;
            cnt    <= CNT_W'(PROC_CYC);
         end else if (busy) begin
            if (cnt == CNT_W'(1)) busy <= 1'b0;
            cnt <= cnt - CNT_W'(1);
         end
         if (host_rd) rdy <= 1'b0;
         if (take) begin
            if (is_cmd) begin
               st <= ST_IDLE;   // any command aborts the one in progress
               case (byte_q)
                  CMD_RD:   st <= ST_RADDR;
                  CMD_WR:   st <= ST_WADDR;
                  CMD_BON:  burst <= 1'b1;
                  CMD_BOFF: burst <= 1'b0;
                  CMD_QRY: begin
                     rdata_q <= evt_idx;
                     rdy     <= 1'b1;
                  end
                  default: ;
               endcase
            end else begin
               case (st)
                  ST_RADDR: begin
                     rdata_q <= mem_rdata;
                     rdy     <= 1'b1;
                     st      <= ST_IDLE;
                  end
                  ST_WADDR: begin
                     waddr_q <= byte_q[ADDR_W-1:0];
                     st      <= ST_WDATA;
                  end
                  ST_WDATA: st <= ST_IDLE;
                  default: ;
               endcase
            end
         end
      end
   end

   assign mem_raddr  = byte_q[ADDR_W-1:0];
   assign mem_we     = take && !is_cmd && (st == ST_WDATA);
   assign mem_waddr  = waddr_q;
   assign mem_wdata  = byte_q;
   assign evt_pop    = take && is_cmd && (byte_q == CMD_QRY);
   assign burst_on   = burst;
   assign host_rdata = rdata_q;

   always_comb begin
      host_status           = '0;
      host_status[SB_RDY]   = rdy;
      host_status[SB_BUSY]  = busy;
      host_status[SB_PROC]  = (st != ST_IDLE);
      host_status[SB_LCMD]  = lcmd;
      host_status[SB_BURST] = burst;
      host_status[SB_EVT]   = evt_any;
   end
endmodule

// File: rtl/ec_hostport.sv
module ec_hostport #(
   parameter int ADDR_W         = 8,
   parameter int NEVT           = 32,
   parameter int PROC_CYC       = 2,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_cmd_sel,
   input  logic [7:0]        host_wdata,
   input  logic              host_rd,
   output logic [7:0]        host_rdata,
   output logic [7:0]        host_status,
   input  logic [NEVT-1:0]   evt_set,
   input  logic              int_we,
   input  logic [ADDR_W-1:0] int_addr,
   input  logic [7:0]        int_wdata,
   input  logic              int_multi
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr
         $error("ADDR_W must be 1..8: an address is one host byte");
      end
      if (NEVT < 1 || NEVT > 255) begin : g_bad_nevt
         $error("NEVT must be 1..255: a query answer is one byte");
      end
      if (PROC_CYC < 1) begin : g_bad_proc
         $error("PROC_CYC must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] mem_raddr, mem_waddr;
   logic [7:0]        mem_rdata, mem_wdata, evt_idx;
   logic              mem_we, evt_pop, evt_any, burst_on;

   ec_hp_seq #(.PROC_CYC(PROC_CYC), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_cmd_sel(host_cmd_sel), .host_wdata(host_wdata),
      .host_rd(host_rd),
      .evt_idx(evt_idx), .evt_any(evt_any),
      .mem_rdata(mem_rdata), .mem_raddr(mem_raddr),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .evt_pop(evt_pop), .burst_on(burst_on),
      .host_rdata(host_rdata), .host_status(host_status)
   );

   ec_hp_evtq #(.NEVT(NEVT)) u_evtq (
      .clk(clk), .rst_n(rst_n),
      .set_vec(evt_set), .pop(evt_pop),
      .any(evt_any), .idx(evt_idx)
   );

   ec_hp_regfile #(.ADDR_W(ADDR_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .h_we(mem_we), .h_waddr(mem_waddr), .h_wdata(mem_wdata),
      .raddr(mem_raddr), .rdata(mem_rdata),
      .i_we(int_we), .i_addr(int_addr), .i_wdata(int_wdata),
      .i_multi(int_multi), .lock(burst_on)
   );
endmodule

// File: rtl/ec_hostport_chk.sv
module ec_hostport_chk #(
   parameter int NEVT = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            host_wr,
   input logic            host_cmd_sel,
   input logic            host_rd,
   input logic [NEVT-1:0] evt_set,
   input logic [5:0]      stat
);
   assert_busy_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr |=> stat[1]);

   assert_lastcmd_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_cmd_sel) |=> stat[3]);

   assert_lastcmd_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !host_cmd_sel) |=> !stat[3]);

   assert_ready_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !stat[1]) |=> !stat[0]);

   assert_proc_only_on_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !stat[1] |=> $stable(stat[2]));

   assert_event_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != '0) |=> stat[5]);

   assert_burst_only_on_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !stat[1] |=> $stable(stat[4]));
endmodule

bind ec_hostport ec_hostport_chk #(.NEVT(NEVT)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .host_wr(host_wr), .host_cmd_sel(host_cmd_sel), .host_rd(host_rd),
   .evt_set(evt_set), .stat(host_status[5:0])
);

// File: tb/ec_hostport_tb.sv
module ec_hostport_tb;
   localparam int NEVT = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_cmd_sel = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata, host_status;
   logic [NEVT-1:0] evt_set = '0;
   logic        int_we = 1'b0, int_multi = 1'b0;
   logic [7:0]  int_addr = '0, int_wdata = '0;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   ec_hostport #(.NEVT(NEVT)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_cmd_sel(host_cmd_sel), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata), .host_status(host_status),
      .evt_set(evt_set),
      .int_we(int_we), .int_addr(int_addr), .int_wdata(int_wdata),
      .int_multi(int_multi)
   );

   typedef struct packed {
      logic [1:0] op;
      logic [7:0] val;
      logic [7:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam logic [1:0] OC = 2'd0;  // command byte
   localparam logic [1:0] OD = 2'd1;  // data byte
   localparam logic [1:0] OR = 2'd2;  // check data port and ready, then read
   localparam logic [1:0] OS = 2'd3;  // status check, val is the mask

   localparam int NV = 47;
   localparam vec_t VT [NV] = '{
      '{OC, 8'h81, 8'h00, 4'd5},  // R5 write 0xA5 to 0x10
      '{OD, 8'h10, 8'h00, 4'd5},
      '{OD, 8'hA5, 8'h00, 4'd5},
      '{OC, 8'h80, 8'h00, 4'd4},  // R4 read back 0x10
      '{OD, 8'h10, 8'h00, 4'd4},
      '{OR, 8'h00, 8'hA5, 4'd4},
      '{OS, 8'h01, 8'h00, 4'd4},  // ready cleared by the read
      '{OC, 8'h81, 8'h00, 4'd5},
      '{OD, 8'h11, 8'h00, 4'd5},
      '{OD, 8'h3C, 8'h00, 4'd5},
      '{OC, 8'h80, 8'h00, 4'd5},
      '{OD, 8'h11, 8'h00, 4'd5},
      '{OR, 8'h00, 8'h3C, 4'd5},
      '{OC, 8'h80, 8'h00, 4'd1},  // R1 untouched byte reads zero
      '{OD, 8'h12, 8'h00, 4'd1},
      '{OR, 8'h00, 8'h00, 4'd1},
      '{OC, 8'h81, 8'h00, 4'd11}, // R11 abort a write with a read
      '{OD, 8'h20, 8'h00, 4'd11},
      '{OC, 8'h80, 8'h00, 4'd11},
      '{OD, 8'h10, 8'h00, 4'd11},
      '{OR, 8'h00, 8'hA5, 4'd11},
      '{OC, 8'h80, 8'h00, 4'd11},
      '{OD, 8'h20, 8'h00, 4'd11},
      '{OR, 8'h00, 8'h00, 4'd11},
      '{OC, 8'h55, 8'h00, 4'd11}, // R11 unknown code, then stray data
      '{OD, 8'h77, 8'h00, 4'd11},
      '{OS, 8'h04, 8'h00, 4'd11},
      '{OC, 8'h80, 8'h00, 4'd11},
      '{OD, 8'h77, 8'h00, 4'd11},
      '{OR, 8'h00, 8'h00, 4'd11},
      '{OD, 8'h99, 8'h00, 4'd11}, // R11 data with nothing in progress
      '{OS, 8'h05, 8'h00, 4'd11},
      '{OC, 8'h82, 8'h00, 4'd9},  // R9 burst on/off
      '{OS, 8'h10, 8'h10, 4'd9},
      '{OC, 8'h83, 8'h00, 4'd9},
      '{OS, 8'h10, 8'h00, 4'd9},
      '{OC, 8'h81, 8'h00, 4'd6},  // R6 processing across a write
      '{OS, 8'h0C, 8'h0C, 4'd6},
      '{OD, 8'h30, 8'h00, 4'd6},
      '{OS, 8'h0C, 8'h04, 4'd6},
      '{OD, 8'h01, 8'h00, 4'd6},
      '{OS, 8'h04, 8'h00, 4'd6},
      '{OC, 8'h80, 8'h00, 4'd6},
      '{OD, 8'h30, 8'h00, 4'd6},
      '{OR, 8'h00, 8'h01, 4'd6},
      '{OC, 8'h84, 8'h00, 4'd7},  // R7 query with nothing pending
      '{OR, 8'h00, 8'h00, 4'd7}
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                        input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put_byte(input logic sel, input logic [7:0] val);
      @(negedge clk);
      host_wr = 1'b1; host_cmd_sel = sel; host_wdata = val;
      @(negedge clk);
      host_wr = 1'b0;
      while (host_status[1]) @(negedge clk);
   endtask

   task automatic take_result(input int req, input logic [7:0] exp);
      @(negedge clk);
      check(req, {31'd0, host_status[0]}, 32'd1, "ready before read");
      check(req, {24'd0, host_rdata}, {24'd0, exp}, "data port");
      host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic rd_addr(input int req, input logic [7:0] a, input logic [7:0] exp);
      put_byte(1'b1, 8'h80);
      put_byte(1'b0, a);
      take_result(req, exp);
   endtask

   task automatic int_write(input logic [7:0] a, input logic [7:0] v, input logic m);
      @(negedge clk);
      int_we = 1'b1; int_addr = a; int_wdata = v; int_multi = m;
      @(negedge clk);
      int_we = 1'b0; int_multi = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(1, {24'd0, host_status}, 32'h00, "status after reset");
      check(1, {24'd0, host_rdata}, 32'h00, "data port after reset");

      // R2 busy timing and R3 last-command flag
      @(negedge clk);
      host_wr = 1'b1; host_cmd_sel = 1'b1; host_wdata = 8'h83;
      @(negedge clk);
      host_wr = 1'b0;
      check(2, {31'd0, host_status[1]}, 32'd1, "busy after write edge");
      check(3, {31'd0, host_status[3]}, 32'd1, "last-cmd after command write");
      @(negedge clk);
      check(2, {31'd0, host_status[1]}, 32'd1, "busy one edge later");
      @(negedge clk);
      check(2, {31'd0, host_status[1]}, 32'd0, "busy cleared at PROC_CYC");
      @(negedge clk);
      host_wr = 1'b1; host_cmd_sel = 1'b0; host_wdata = 8'h00;
      @(negedge clk);
      host_wr = 1'b0;
      check(3, {31'd0, host_status[3]}, 32'd0, "last-cmd after data write");
      while (host_status[1]) @(negedge clk);

      // table walk
      for (int i = 0; i < NV; i++) begin
         case (VT[i].op)
            OC: put_byte(1'b1, VT[i].val);
            OD: put_byte(1'b0, VT[i].val);
            OR: take_result(int'(VT[i].req), VT[i].exp);
            default: begin
               @(negedge clk);
               check(int'(VT[i].req), {24'd0, host_status & VT[i].val},
                     {24'd0, VT[i].exp}, "status field");
            end
         endcase
      end

      // R8 event flag and R7 query order
      @(negedge clk);
      evt_set = 32'h8000_0024;
      @(negedge clk);
      evt_set = '0;
      check(8, {31'd0, host_status[5]}, 32'd1, "event flag after pulses");
      put_byte(1'b1, 8'h84);
      take_result(7, 8'd3);
      put_byte(1'b1, 8'h84);
      take_result(7, 8'd6);
      check(8, {31'd0, host_status[5]}, 32'd1, "event flag with one left");
      put_byte(1'b1, 8'h84);
      take_result(7, 8'd32);
      check(8, {31'd0, host_status[5]}, 32'd0, "event flag when empty");
      put_byte(1'b1, 8'h84);
      take_result(7, 8'd0);

      // R10 internal writes under burst
      put_byte(1'b1, 8'h82);
      int_write(8'h40, 8'h11, 1'b1);
      int_write(8'h41, 8'h22, 1'b0);
      put_byte(1'b1, 8'h83);
      int_write(8'h42, 8'h33, 1'b1);
      rd_addr(10, 8'h40, 8'h00);
      rd_addr(10, 8'h41, 8'h22);
      rd_addr(10, 8'h42, 8'h33);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule